// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block sequences instruction fetch for a small 8-bit controller core. It keeps a 13-bit program counter. From that counter it drives the word address of a 14-bit instruction store that holds only 1K words. The architectural space is 8K words, so every counter value above 3FFh reaches the same physical word as its low ten bits. Each cycle the counter does one of the following:
- holds its value;
- steps forward by one;
- loads a jump target;
- performs a call;
- takes an interrupt to the fixed entry word 0004h;
- returns to an address popped from an eight-entry stack.

Three kinds of return strobe pop the stack: plain, interrupt and literal. They act the same way on the counter. The literal kind also hands an 8-bit value to the working-register logic, which sits outside this block. All pins are plain control strobes with no handshake. The sequencer accepts every strobe in the cycle it is asserted and never stalls its neighbours. The decoder must therefore raise each strobe for exactly one cycle per instruction. All effects appear on the outputs one clock edge after the strobe.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, the counter is 0000h, the stack pointer is cleared, all stack entries are zero and `lit_valid` is 0. The counter clears asynchronously, so `fetch_addr` reads 000h while reset is held.
- R2: When no interrupt, return or jump strobe is active, the counter advances by one (modulo 2^13) on each edge where `step_en` is 1. When `step_en` is 0, the counter holds.
- R3: `jump_go` with `jump_is_call` = 0 loads `jump_target` into the counter and leaves the stack unchanged.
- R4: `jump_go` with `jump_is_call` = 1 loads `jump_target` and pushes the counter value plus one, computed modulo 2^13. A call made at 1FFFh therefore returns to 0000h.
- R5: `irq_take` pushes the current counter value unchanged and loads 0004h.
- R6: `ret_go`, `ret_from_irq` and `ret_lit` each pop the stack and load the popped address into the counter. If several of them are raised in the same cycle, the stack pops only once. Priority is fixed, highest first: interrupt, any return, jump or call, step.
- R7: `fetch_addr` equals the counter's low 10 bits. For example, a jump to 1405h fetches word 005h, and stepping from 03FFh fetches word 000h.
- R8: The stack holds 8 entries in a circle. A ninth push without a pop overwrites the oldest entry. Nine pushes of A1..A9 followed by nine pops return A9, A8, ..., A2 and then A9 again.
- R9: Popping an empty stack is not flagged. It returns whatever entry the pointer selects, which is 0000h directly after reset.
- R10: On the edge that accepts `ret_lit`, `lit_out` takes the value on `lit_in`, and `lit_valid` is 1 for that one following cycle only. `lit_out` keeps its value otherwise, and `ret_go` and `ret_from_irq` never raise `lit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance the counter by one |
| jump_go | input | 1 | Load `jump_target` this cycle |
| jump_is_call | input | 1 | With `jump_go`, also push the return address |
| jump_target | input | 13 | Jump or call destination |
| irq_take | input | 1 | Interrupt accepted: push the counter and go to 0004h |
| ret_go | input | 1 | Plain return: pop |
| ret_from_irq | input | 1 | Return from interrupt: pop |
| ret_lit | input | 1 | Return with literal: pop and capture `lit_in` |
| lit_in | input | 8 | Literal that comes with `ret_lit` |
| fetch_addr | output | 10 | Physical instruction word address |
| lit_out | output | 8 | Captured literal |
| lit_valid | output | 1 | One-cycle pulse after `ret_lit` |

## Verification
A corrupted counter shows on `fetch_addr` at the next edge, but only in the low ten bits. The three upper bits never reach a port directly. They surface only when a pushed or compared address later depends on them.

A wrong stack pointer or a bad stack entry stays hidden for as long as calls keep nesting. It appears as a wrong `fetch_addr` one cycle after the return that reads the affected slot, which may come many cycles later. For that reason the stimulus unwinds every stack it builds, including past the wrap point.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // What the counter does on the coming edge, already prioritised.
  typedef enum logic [2:0] {
    ACT_HOLD = 3'd0,
    ACT_STEP = 3'd1,
    ACT_JUMP = 3'd2,
    ACT_CALL = 3'd3,
    ACT_IRQ  = 3'd4,
    ACT_RET  = 3'd5
  } pc_act_e;

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
  import pcseq_pkg::*;
(
  input  logic    irq_take,
  input  logic    ret_any,
  input  logic    jump_go,
  input  logic    jump_is_call,
  input  logic    step_en,
  output pc_act_e act
);

  // Fixed priority: interrupt, return, jump/call, step, hold (R6).
  always_comb begin
    if (irq_take)     act = ACT_IRQ;
    else if (ret_any) act = ACT_RET;
    else if (jump_go) act = jump_is_call ? ACT_CALL : ACT_JUMP;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  // R6: exactly one action is chosen whenever any strobe is active.
  always_comb begin
    a_r6_single_action: assert ((irq_take || ret_any || jump_go || step_en) == (act != ACT_HOLD))
      else $error("a_r6_single_action");
  end

endmodule

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
  parameter int DEPTH = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_inc;
  logic [PTR_W-1:0]  ptr_dec;
  logic [ADDR_W-1:0] slot_q [DEPTH];

  // Circular pointer arithmetic that does not rely on DEPTH being a power of two.
  assign ptr_inc = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_ONE;
  assign ptr_dec = (ptr_q == '0) ? PTR_LAST : ptr_q - PTR_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push) begin
      ptr_q <= ptr_inc;
    end else if (pop) begin
      ptr_q <= ptr_dec;
    end
  end

  // One register per slot. A push writes the slot under the pointer, so the
  // oldest slot is overwritten once the circle is full (R8).
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (push && (ptr_q == PTR_W'(g))) begin
        slot_q[g] <= push_data;
      end
    end
  end

  // Entry just below the pointer; on an empty stack this is simply whatever
  // that slot holds (R9).
  assign top_data = slot_q[ptr_dec];

  a_r8_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ptr_q == $past(ptr_inc))
    else $error("a_r8_push_advances");

  a_r8_push_stores: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> slot_q[$past(ptr_q)] == $past(push_data))
    else $error("a_r8_push_stores");

  a_r6_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> ptr_q == $past(ptr_dec))
    else $error("a_r6_pop_retreats");

  a_r6_no_push_and_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop))
    else $error("a_r6_no_push_and_pop");

endmodule

// File: rtl/pcseq_litlatch.sv
module pcseq_litlatch #(
  parameter int LIT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LIT_W-1:0] lit_in,
  output logic [LIT_W-1:0] lit_q,
  output logic             valid_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) lit_q <= lit_in;
    end
  end

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (valid_q && lit_q == $past(lit_in)))
    else $error("a_r10_pulse");

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!valid_q && $stable(lit_q)))
    else $error("a_r10_hold");

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int PHYS_W = 10,
  parameter int DEPTH  = 8,
  parameter int LIT_W  = 8,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC   = PC_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              jump_go,
  input  logic              jump_is_call,
  input  logic [PC_W-1:0]   jump_target,
  input  logic              irq_take,
  input  logic              ret_go,
  input  logic              ret_from_irq,
  input  logic              ret_lit,
  input  logic [LIT_W-1:0]  lit_in,
  output logic [PHYS_W-1:0] fetch_addr,
  output logic [LIT_W-1:0]  lit_out,
  output logic              lit_valid
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  pc_act_e         act;
  logic            ret_any;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_plus1;
  logic [PC_W-1:0] stack_top;
  logic [PC_W-1:0] push_val;
  logic            do_push;
  logic            do_pop;

  assign ret_any  = ret_go || ret_from_irq || ret_lit;
  assign pc_plus1 = pc_q + PC_ONE;

  pcseq_arbiter u_arb (
    .irq_take     (irq_take),
    .ret_any      (ret_any),
    .jump_go      (jump_go),
    .jump_is_call (jump_is_call),
    .step_en      (step_en),
    .act          (act)
  );

  // Interrupt saves the counter as is; a call saves the following word.
  assign do_push  = (act == ACT_IRQ) || (act == ACT_CALL);
  assign do_pop   = (act == ACT_RET);
  assign push_val = (act == ACT_CALL) ? pc_plus1 : pc_q;

  pcseq_retstack #(
    .DEPTH  (DEPTH),
    .ADDR_W (PC_W)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .push_data (push_val),
    .pop       (do_pop),
    .top_data  (stack_top)
  );

  pcseq_litlatch #(
    .LIT_W (LIT_W)
  ) u_lit (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (do_pop && ret_lit),
    .lit_in  (lit_in),
    .lit_q   (lit_out),
    .valid_q (lit_valid)
  );

  always_comb begin
    unique case (act)
      ACT_STEP:          pc_d = pc_plus1;
      ACT_JUMP,
      ACT_CALL:          pc_d = jump_target;
      ACT_IRQ:           pc_d = IRQ_VEC;
      ACT_RET:           pc_d = stack_top;
      default:           pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_VEC;
    else        pc_q <= pc_d;
  end

  // Upper counter bits alias: only the implemented window is addressed (R7).
  assign fetch_addr = pc_q[PHYS_W-1:0];

  a_r1_reset_vector: assert property (@(posedge clk)
    $rose(rst_n) |-> pc_q == RESET_VEC)
    else $error("a_r1_reset_vector");

  a_r5_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_q == IRQ_VEC)
    else $error("a_r5_irq_entry");

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !irq_take && !ret_any && !jump_go) |=> pc_q == $past(pc_q) + PC_ONE)
    else $error("a_r2_step");

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !irq_take && !ret_any && !jump_go) |=> $stable(pc_q))
    else $error("a_r2_hold");

  a_r3_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_go && !irq_take && !ret_any) |=> pc_q == $past(jump_target))
    else $error("a_r3_jump_load");

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic        jump_go = 1'b0;
  logic        jump_is_call = 1'b0;
  logic [12:0] jump_target = '0;
  logic        irq_take = 1'b0;
  logic        ret_go = 1'b0;
  logic        ret_from_irq = 1'b0;
  logic        ret_lit = 1'b0;
  logic [7:0]  lit_in = '0;
  logic [9:0]  fetch_addr;
  logic [7:0]  lit_out;
  logic        lit_valid;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .jump_go      (jump_go),
    .jump_is_call (jump_is_call),
    .jump_target  (jump_target),
    .irq_take     (irq_take),
    .ret_go       (ret_go),
    .ret_from_irq (ret_from_irq),
    .ret_lit      (ret_lit),
    .lit_in       (lit_in),
    .fetch_addr   (fetch_addr),
    .lit_out      (lit_out),
    .lit_valid    (lit_valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // One edge; inputs change 1 ns after it, outputs are read there too.
  task automatic edge_then_clear();
    @(posedge clk);
    #1;
    step_en = 0; jump_go = 0; jump_is_call = 0; irq_take = 0;
    ret_go = 0; ret_from_irq = 0; ret_lit = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0;
    #1;
    chk("R1 async fetch", 32'(fetch_addr), 32'h0);
    @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic do_jump(input logic [12:0] t);
    jump_go = 1; jump_target = t; edge_then_clear();
  endtask
  task automatic do_call(input logic [12:0] t);
    jump_go = 1; jump_is_call = 1; jump_target = t; edge_then_clear();
  endtask
  task automatic do_irq();
    irq_take = 1; edge_then_clear();
  endtask
  task automatic do_ret(input int kind);
    if (kind == 0) ret_go = 1;
    else if (kind == 1) ret_from_irq = 1;
    else ret_lit = 1;
    edge_then_clear();
  endtask
  task automatic do_steps(input int n);
    for (int i = 0; i < n; i++) begin
      step_en = 1; edge_then_clear();
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 fetch", 32'(fetch_addr), 32'h0);
    chk("R1 lit_valid", 32'(lit_valid), 32'h0);
    edge_then_clear();
    chk("R2 hold without step", 32'(fetch_addr), 32'h0);
  endtask

  task automatic t_step();
    do_reset();
    do_steps(5);
    chk("R2 five steps", 32'(fetch_addr), 32'h5);
    edge_then_clear();
    edge_then_clear();
    chk("R2 hold", 32'(fetch_addr), 32'h5);
  endtask

  task automatic t_jump_alias();
    do_reset();
    do_jump(13'h1405);
    chk("R7 alias of 1405h", 32'(fetch_addr), 32'h005);
    do_steps(1);
    chk("R2 step after jump", 32'(fetch_addr), 32'h006);
    do_jump(13'h03FF);
    chk("R3 jump 3FFh", 32'(fetch_addr), 32'h3FF);
    do_steps(1);
    chk("R7 step past 3FFh", 32'(fetch_addr), 32'h000);
    do_ret(0);
    chk("R3 jump left stack empty", 32'(fetch_addr), 32'h000);
  endtask

  task automatic t_call_return();
    do_reset();
    do_jump(13'h010);
    do_call(13'h200);
    chk("R4 call target", 32'(fetch_addr), 32'h200);
    do_steps(2);
    do_call(13'h300);
    chk("R4 nested call", 32'(fetch_addr), 32'h300);
    do_ret(0);
    chk("R6 plain return", 32'(fetch_addr), 32'h203);
    do_ret(1);
    chk("R6 irq-kind return", 32'(fetch_addr), 32'h011);
  endtask

  task automatic t_call_wrap();
    do_reset();
    do_jump(13'h1FFF);
    do_call(13'h100);
    chk("R4 call from 1FFFh", 32'(fetch_addr), 32'h100);
    do_ret(0);
    chk("R4 return address wraps to 0", 32'(fetch_addr), 32'h000);
  endtask

  task automatic t_irq_priority();
    do_reset();
    do_jump(13'h123);
    irq_take = 1; jump_go = 1; jump_target = 13'h0AA; ret_go = 1; step_en = 1;
    edge_then_clear();
    chk("R5 irq wins", 32'(fetch_addr), 32'h004);
    do_ret(1);
    chk("R5 resume at interrupted word", 32'(fetch_addr), 32'h123);
    do_jump(13'h050);
    do_call(13'h060);
    ret_go = 1; jump_go = 1; jump_target = 13'h070; step_en = 1;
    edge_then_clear();
    chk("R6 return beats jump", 32'(fetch_addr), 32'h051);
    do_call(13'h080);
    ret_go = 1; ret_from_irq = 1; ret_lit = 1;
    edge_then_clear();
    chk("R6 combined return", 32'(fetch_addr), 32'h052);
    do_ret(0);
    chk("R6 single pop (empty again)", 32'(fetch_addr), 32'h000);
  endtask

  task automatic t_wrap_stack();
    do_reset();
    for (int i = 1; i <= 9; i++) begin
      do_jump(13'(13'h040 + i));
      do_irq();
    end
    chk("R5 vector after nine", 32'(fetch_addr), 32'h004);
    for (int k = 0; k < 9; k++) begin
      do_ret(0);
      chk("R8 circular pop order", 32'(fetch_addr),
          (k < 8) ? 32'(32'h040 + 9 - k) : 32'h049);
    end
  endtask

  task automatic t_empty_pop();
    do_reset();
    do_jump(13'h155);
    do_call(13'h0F0);
    do_reset();
    chk("R1 reset mid-run", 32'(fetch_addr), 32'h000);
    do_jump(13'h077);
    do_ret(1);
    chk("R9 empty pop after reset", 32'(fetch_addr), 32'h000);
  endtask

  task automatic t_literal();
    do_reset();
    do_jump(13'h020);
    do_call(13'h100);
    do_call(13'h180);
    lit_in = 8'hA5;
    do_ret(2);
    chk("R10 return addr", 32'(fetch_addr), 32'h101);
    chk("R10 valid pulse", 32'(lit_valid), 32'h1);
    chk("R10 literal", 32'(lit_out), 32'hA5);
    lit_in = 8'h3C;
    edge_then_clear();
    chk("R10 pulse ends", 32'(lit_valid), 32'h0);
    chk("R10 literal held", 32'(lit_out), 32'hA5);
    do_ret(0);
    chk("R10 plain return no pulse", 32'(lit_valid), 32'h0);
    chk("R10 literal kept", 32'(lit_out), 32'hA5);
    chk("R6 plain pop", 32'(fetch_addr), 32'h021);
  endtask

  initial begin
    t_reset_state();
    t_step();
    t_jump_alias();
    t_call_return();
    t_call_wrap();
    t_irq_priority();
    t_wrap_stack();
    t_empty_pop();
    t_literal();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule